// File: doc/BRIEF.md
# Staged 64-Bit Output Image Register

This block keeps a 64-bit output image for a bank of isolated output switches and updates it in two steps. A host writes the image as four 16-bit words over a simple local bus. Those writes only fill a shadow image, and the pins stay as they are. A write to a separate start address then copies the shadow into a transfer stage. After a fixed send time, which stands for the serial shift to the isolated drivers, all 64 pins change on the same clock edge. A bit value of 1 turns its switch on and 0 turns it off.

Reading the live pins is also a two-step procedure. A read of a command address carries no data. It takes a snapshot of the pins and starts a short readback procedure. Four readback words then return that snapshot until the next such command. A status word shows a busy flag for each procedure. A cold reset loads the outputs with a parameter pattern that defaults to all off. A bus-writable preload image sets the value that a warm reset applies, and a hold control bit lets a warm reset leave the outputs untouched.

Top module: `dout_staged_outreg`

## Requirements
- R1: Writes to addresses 0 to 3 place word k into shadow bits [16k+15:16k] and do not change the output pins.
- R2: A write of any data to address 4 while no send is running copies the shadow image. The send-busy flag is then high for SEND_CYCLES cycles, and all 64 pins take the copied value together on the last clock edge of that window.
- R3: A start write while a send is running is ignored, and the send in flight delivers the shadow value from the start that was accepted. Later shadow writes are kept for the next start.
- R4: A read of address 5 while no readback is running captures the output pins of that cycle into a snapshot and raises the readback-busy flag for RB_CYCLES cycles. The read itself returns 0.
- R5: Reads of addresses 6 to 9 return snapshot word k (bits [16k+15:16k]) and keep that value until the next accepted readback command, even when the pins change.
- R6: A read of address 10 returns status: bit 0 is send busy, bit 1 is readback busy, and each reads 1 while its procedure runs and 0 otherwise. Bit 2 is the hold control bit and the other bits are 0.
- R7: After a cold reset (rst_n low) the pins equal PWRUP_INIT (default all zero, every switch off), both busy flags are 0 and hold is 0.
- R8: Writes to addresses 12 to 15 fill preload word k without touching the pins. A warm-reset cycle with hold at 0 loads the pins with the preload image.
- R9: Bit 0 written to address 11 is the hold control. A warm-reset cycle with hold at 1 leaves the pins unchanged. Any warm-reset cycle aborts a running send or readback, and the aborted send never reaches the pins.
- R10: Read data is registered and appears on the cycle after the read strobe. Reads of write-only or unmapped addresses return 0, and bus_rdata is 0 in cycles after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset request, synchronous, one cycle |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| out_pins | output | 64 | Output switch image, 1 = on |

## Verification
The assertions assume that bus_wr and bus_rd are never high in the same cycle. They also assume that a warm-reset request lasts one cycle and comes with no bus access. The bench drives every access from a task that raises exactly one strobe for one cycle, and it keeps warm-reset pulses apart from bus traffic. The pins are checked on both sides of the edge where a send finishes. Accesses are placed during busy windows so that the ignored starts and the held snapshot are exercised.

// File: rtl/dout_pkg.sv
package dout_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADR_SHADOW  = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_START   = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_RBSTART = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_RBWORD  = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_STATUS  = 4'd10;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'd11;
    localparam logic [ADDR_W-1:0] ADR_PRELOAD = 4'd12;

    localparam int ST_SEND_BIT = 0;
    localparam int ST_RB_BIT   = 1;
    localparam int ST_HOLD_BIT = 2;
endpackage

// File: rtl/dout_busy_timer.sv
module dout_busy_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear) begin
            tmr_d.busy = 1'b0;
            tmr_d.cnt  = '0;
        end else if (!tmr_q.busy && start) begin
            tmr_d.busy = 1'b1;
            tmr_d.cnt  = CW'(CYCLES);
        end else if (tmr_q.busy) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
            if (tmr_q.cnt == CW'(1)) tmr_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy_o = tmr_q.busy;
    assign done_o = tmr_q.busy && (tmr_q.cnt == CW'(1)) && !clear;

    // R2 / R4: the remaining count stays inside the window while busy
    p_count_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (tmr_q.cnt >= CW'(1) && tmr_q.cnt <= CW'(CYCLES)));

    // R6: the busy flag drops right after the final cycle
    p_done_clears_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
endmodule

// File: rtl/dout_word_bank.sv
module dout_word_bank #(
    parameter int                      NWORDS    = 4,
    parameter int                      WW        = 16,
    parameter logic [NWORDS*WW-1:0]    RESET_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(NWORDS)-1:0]  wr_idx,
    input  logic [WW-1:0]              wr_data,
    output logic [NWORDS*WW-1:0]       image_o
);
    logic [NWORDS*WW-1:0] img_d, img_q;

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        assign img_d[k*WW +: WW] = (wr_en && wr_idx == k) ? wr_data
                                                         : img_q[k*WW +: WW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) img_q <= RESET_VAL;
        else        img_q <= img_d;
    end

    assign image_o = img_q;
endmodule

// File: rtl/dout_staged_outreg.sv
module dout_staged_outreg
    import dout_pkg::*;
#(
    parameter int                    NWORDS      = 4,
    parameter int                    SEND_CYCLES = 16,
    parameter int                    RB_CYCLES   = 4,
    parameter logic [NWORDS*16-1:0]  PWRUP_INIT  = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    warm_rst,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic [WORD_W-1:0]       bus_wdata,
    output logic [WORD_W-1:0]       bus_rdata,
    output logic [NWORDS*WORD_W-1:0] out_pins
);
    localparam int OUT_W = NWORDS * WORD_W;
    localparam int IDX_W = $clog2(NWORDS);

    typedef struct packed {
        logic [OUT_W-1:0]  outv;
        logic [OUT_W-1:0]  stage;
        logic [OUT_W-1:0]  snap;
        logic              hold;
        logic [WORD_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic             send_busy, send_done, rb_busy, rb_done;
    logic             send_go, rb_go, wr_shadow, wr_preload;
    logic [OUT_W-1:0] shadow_img, preload_img;
    logic [ADDR_W-1:0] off_shadow, off_rb, off_pre;
    logic [IDX_W-1:0] idx_shadow, idx_rb, idx_pre;

    function automatic logic in_region(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base);
        return (a >= base) && ({1'b0, a} < {1'b0, base} + (ADDR_W+1)'(NWORDS));
    endfunction

    always_comb begin
        off_shadow = bus_addr - ADR_SHADOW;
        off_rb     = bus_addr - ADR_RBWORD;
        off_pre    = bus_addr - ADR_PRELOAD;
        idx_shadow = off_shadow[IDX_W-1:0];
        idx_rb     = off_rb[IDX_W-1:0];
        idx_pre    = off_pre[IDX_W-1:0];
        wr_shadow  = bus_wr && in_region(bus_addr, ADR_SHADOW);
        wr_preload = bus_wr && in_region(bus_addr, ADR_PRELOAD);
        send_go    = bus_wr && (bus_addr == ADR_START)   && !send_busy && !warm_rst;
        rb_go      = bus_rd && (bus_addr == ADR_RBSTART) && !rb_busy   && !warm_rst;
    end

    dout_word_bank #(.NWORDS(NWORDS), .WW(WORD_W), .RESET_VAL('0)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_shadow), .wr_idx(idx_shadow),
        .wr_data(bus_wdata), .image_o(shadow_img));

    dout_word_bank #(.NWORDS(NWORDS), .WW(WORD_W), .RESET_VAL(PWRUP_INIT)) u_preload (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_preload), .wr_idx(idx_pre),
        .wr_data(bus_wdata), .image_o(preload_img));

    dout_busy_timer #(.CYCLES(SEND_CYCLES)) u_send_tmr (
        .clk(clk), .rst_n(rst_n), .clear(warm_rst), .start(send_go),
        .busy_o(send_busy), .done_o(send_done));

    dout_busy_timer #(.CYCLES(RB_CYCLES)) u_rb_tmr (
        .clk(clk), .rst_n(rst_n), .clear(warm_rst), .start(rb_go),
        .busy_o(rb_busy), .done_o(rb_done));

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;

        if (send_go)   st_d.stage = shadow_img;
        if (send_done) st_d.outv  = st_q.stage;
        if (rb_go)     st_d.snap  = st_q.outv;
        if (bus_wr && bus_addr == ADR_CTRL) st_d.hold = bus_wdata[0];

        if (warm_rst) st_d.outv = st_q.hold ? st_q.outv : preload_img;

        if (bus_rd) begin
            if (in_region(bus_addr, ADR_RBWORD)) begin
                st_d.rdata = st_q.snap[idx_rb*WORD_W +: WORD_W];
            end else if (bus_addr == ADR_STATUS) begin
                st_d.rdata[ST_SEND_BIT] = send_busy;
                st_d.rdata[ST_RB_BIT]   = rb_busy;
                st_d.rdata[ST_HOLD_BIT] = st_q.hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.outv  <= PWRUP_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_pins  = st_q.outv;
    assign bus_rdata = st_q.rdata;

    // R1: pins move only when a send finishes or on a warm reset
    p_pins_move_on_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!send_done && !warm_rst) |=> $stable(out_pins));

    // R3: the staged value is frozen while a send is in flight
    p_stage_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        send_busy |=> $stable(st_q.stage));

    // R5: the snapshot changes only on a readback command
    p_snap_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == ADR_RBSTART) |=> $stable(st_q.snap));

    // R9: warm reset with hold set leaves the pins alone
    p_hold_keeps_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst && st_q.hold) |=> $stable(out_pins));

    // R10: no read means zero read data on the next cycle
    p_rdata_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/sim_dout_staged_outreg.sv
module sim_dout_staged_outreg;
    localparam int N  = 16;
    localparam int RB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [63:0] out_pins;

    int checks = 0;
    int errors = 0;
    logic pend = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    dout_staged_outreg #(.NWORDS(4), .SEND_CYCLES(N), .RB_CYCLES(RB),
                         .PWRUP_INIT(64'h0)) u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .out_pins(out_pins));

    always @(posedge clk) pend <= bus_rd;

    // monitor: compare registered read data against the scoreboard
    always @(negedge clk) begin
        if (pend) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                errors++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr64(input logic [3:0] base, input logic [63:0] v);
        for (int k = 0; k < 4; k++) wr(base + 4'(k), v[k*16 +: 16]);
    endtask

    task automatic rd64(input logic [3:0] base, input logic [63:0] v, input string t);
        for (int k = 0; k < 4; k++) rd(base + 4'(k), v[k*16 +: 16], t);
    endtask

    task automatic warm();
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
    endtask

    task automatic chk_pins(input logic [63:0] e, input string t);
        checks++;
        if (out_pins !== e) begin
            errors++;
            $display("FAIL %s: pins actual %h expected %h", t, out_pins, e);
        end
    endtask

    localparam logic [63:0] X1 = 64'hA5A5_0F0F_1234_8001;
    localparam logic [63:0] X2 = 64'h0000_FFFF_0000_FFFF;
    localparam logic [63:0] X3 = 64'h8421_4218_2184_1842;
    localparam logic [63:0] X4 = 64'hDEAD_BEEF_CAFE_F00D;
    localparam logic [63:0] X5 = 64'h1111_2222_3333_4444;
    localparam logic [63:0] X6 = 64'hFFFF_FFFF_FFFF_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_pins(64'h0, "R7 cold reset pins");
        rd(4'd10, 16'h0000, "R7 status after reset");

        // single send, exact timing
        wr64(4'd0, X1);
        chk_pins(64'h0, "R1 shadow write keeps pins");
        wr(4'd4, 16'h0);
        repeat (N-1) @(negedge clk);
        chk_pins(64'h0, "R2 pins before send end");
        @(negedge clk);
        chk_pins(X1, "R2 pins at send end");

        // start during busy ignored
        wr64(4'd0, X2);
        wr(4'd4, 16'h0);
        wr64(4'd0, X3);
        wr(4'd4, 16'h0);
        rd(4'd10, 16'h0001, "R6 send busy flag");
        repeat (N+2) @(negedge clk);
        chk_pins(X2, "R3 ignored start keeps in-flight value");
        rd(4'd10, 16'h0000, "R6 send idle flag");
        wr(4'd4, 16'h0);
        repeat (N+1) @(negedge clk);
        chk_pins(X3, "R3 later shadow writes kept");

        // readback snapshot
        rd(4'd5, 16'h0000, "R4 readback command returns 0");
        rd(4'd10, 16'h0002, "R6 readback busy flag");
        wr64(4'd0, X4);
        wr(4'd4, 16'h0);
        repeat (N+1) @(negedge clk);
        chk_pins(X4, "R2 second send");
        rd64(4'd6, X3, "R5 snapshot held after pins change");
        rd(4'd5, 16'h0000, "R4 readback command");
        repeat (RB+1) @(negedge clk);
        rd64(4'd6, X4, "R4 new snapshot");
        rd(4'd10, 16'h0000, "R6 all idle");

        // warm reset paths
        wr64(4'd12, X5);
        chk_pins(X4, "R8 preload write keeps pins");
        warm();
        chk_pins(X5, "R8 warm reset loads preload");
        wr(4'd11, 16'h0001);
        rd(4'd10, 16'h0004, "R9 hold bit in status");
        wr(4'd4, 16'h0);
        repeat (N+1) @(negedge clk);
        chk_pins(X4, "R2 send with unchanged shadow");
        warm();
        chk_pins(X4, "R9 hold keeps pins");
        wr64(4'd0, X6);
        wr(4'd4, 16'h0);
        repeat (3) @(negedge clk);
        warm();
        repeat (N+2) @(negedge clk);
        chk_pins(X4, "R9 warm reset aborts send");
        rd(4'd10, 16'h0004, "R9 busy cleared by warm reset");

        rd(4'd0, 16'h0000, "R10 write-only shadow reads 0");
        rd(4'd11, 16'h0000, "R10 control reads 0");
        rd(4'd4, 16'h0000, "R10 start address reads 0");

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk_pins(64'h0, "R7 second cold reset");
        rd(4'd10, 16'h0000, "R7 hold cleared by cold reset");
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule